// File: doc/BRIEF.md
# Dual-Frame Doorbell Mailbox

A doorbell link between a sending processor and a receiving processor. Each side has its own register frame on its own simple one-cycle bus. Both frames share two 32-bit flag words, one per channel. The sender raises bits in a flag word. The receiver sees the word in its status view. An interrupt per channel stays high while any bit of that channel is set. The receiver acknowledges a message by clearing the bits it handled. The sender knows the message was consumed when the status word reads back as zero.

Before it signals anything, the sender must raise a wake request. A ready flag answers the request after a fixed delay and is mirrored to the receiver as an awake output. Dropping the request only lets the receiver sleep; the mailbox never forces it to sleep. A capability register tells software how many channels exist.

Top module: `dbell_mbox`

## Requirements
- R1: After reset both flag words are zero, both interrupts are low, and ready, request and awake are all zero.
- R2: In both frames, the status register of channel 0 (high priority, offset 0x00) and of channel 1 (low priority, offset 0x20) returns that channel's current flag word.
- R3: A sender-frame write to channel offset 0x0C (0x0C or 0x2C) ORs the write data into that channel's flag word, provided ready is 1.
- R4: A sender set write made while ready is 0 leaves the flag word unchanged.
- R5: A receiver-frame write to channel offset 0x08 (0x08 or 0x28) clears each flag bit whose write-data bit is 1 and keeps the other bits.
- R6: When a set and a clear reach the same bit in the same cycle, the bit ends up set.
- R7: rx_irq_o[c] is 1 exactly when flag word c is nonzero; bit 0 belongs to the channel at 0x00 and bit 1 to the channel at 0x20.
- R8: The sender-frame register at 0xF80 reads 2, the number of channels.
- R9: Bit 0 of a sender-frame write to 0xF88 sets the request, which reads back at 0xF88. The ready bit, bit 0 of 0xF8C, rises WAKE_DLY cycles (default 4) after the request reads 1, and rx_awake_o follows ready.
- R10: One cycle after the request is cleared, ready and rx_awake_o read 0.
- R11: Unmapped offsets read zero and writes to them change nothing. This covers the set and clear offsets when read, and 0xF80 to 0xF8C in the receiver frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tx_sel_i | input | 1 | Sender frame transfer valid |
| tx_write_i | input | 1 | Sender frame write (1) or read (0) |
| tx_addr_i | input | 12 | Sender frame byte address |
| tx_wdata_i | input | 32 | Sender frame write data |
| tx_rdata_o | output | 32 | Sender frame read data, same cycle |
| rx_sel_i | input | 1 | Receiver frame transfer valid |
| rx_write_i | input | 1 | Receiver frame write (1) or read (0) |
| rx_addr_i | input | 12 | Receiver frame byte address |
| rx_wdata_i | input | 32 | Receiver frame write data |
| rx_rdata_o | output | 32 | Receiver frame read data, same cycle |
| rx_irq_o | output | 2 | Per-channel interrupt, high while the flag word is nonzero |
| rx_awake_o | output | 1 | Wake indication to the receiver, equal to ready |

## Verification
The assertions check on every cycle that flag bits appear only after a cycle with ready high, that ready rises only under a request held over two cycles and falls after the request drops, that a full-mask clear without a competing set silences the interrupt, that the capability read returns the channel count, and that unmapped writes leave the flags unchanged. The exact wake delay, the set-wins rule on a shared bit, the equality of the two status views, and the OR and mask arithmetic over many random data patterns can be shown only by the bench's scenarios, which compare against a reference model.

// File: rtl/dbell_pkg.sv
package dbell_pkg;
  localparam int unsigned WIN_BITS = 5;            // 32-byte channel window
  localparam logic [4:0]  STAT_OFS = 5'h00;
  localparam logic [4:0]  CLR_OFS  = 5'h08;
  localparam logic [4:0]  SET_OFS  = 5'h0C;
  localparam int unsigned CAP_ADDR = 'hF80;
  localparam int unsigned REQ_ADDR = 'hF88;
  localparam int unsigned RDY_ADDR = 'hF8C;
endpackage

// File: rtl/dbell_win_dec.sv
module dbell_win_dec import dbell_pkg::*; #(
  parameter int unsigned NCH = 2,
  parameter int unsigned AW  = 12
) (
  input  logic [AW-1:0]  addr_i,
  output logic [NCH-1:0] ch_hit_o,
  output logic [4:0]     off_o
);
  localparam int unsigned WB = AW - WIN_BITS;

  assign off_o = addr_i[WIN_BITS-1:0];

  for (genvar c = 0; c < NCH; c++) begin : g_hit
    assign ch_hit_o[c] = (addr_i[AW-1:WIN_BITS] == WB'(c));
  end
endmodule

// File: rtl/dbell_chan.sv
module dbell_chan #(
  parameter int unsigned DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          set_en_i,
  input  logic [DW-1:0] set_val_i,
  input  logic          clr_en_i,
  input  logic [DW-1:0] clr_val_i,
  output logic [DW-1:0] flag_o,
  output logic          irq_o
);
  logic [DW-1:0] set_m, clr_m;

  assign set_m = set_en_i ? set_val_i : '0;
  assign clr_m = clr_en_i ? clr_val_i : '0;

  // set applied after clear: set wins on a shared bit
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_o <= '0;
    else         flag_o <= (flag_o & ~clr_m) | set_m;
  end

  assign irq_o = |flag_o;
endmodule

// File: rtl/dbell_wake.sv
module dbell_wake #(
  parameter int unsigned DLY = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_wr_i,
  input  logic req_val_i,
  output logic req_o,
  output logic rdy_o
);
  localparam int unsigned CW = (DLY < 2) ? 1 : $clog2(DLY + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_o <= 1'b0;
      rdy_o <= 1'b0;
      cnt_q <= '0;
    end else begin
      if (req_wr_i) req_o <= req_val_i;
      if (!req_o) begin
        rdy_o <= 1'b0;
        cnt_q <= '0;
      end else if (!rdy_o) begin
        if (cnt_q == CW'(DLY - 1)) rdy_o <= 1'b1;
        else                       cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/dbell_mbox.sv
module dbell_mbox import dbell_pkg::*; #(
  parameter int unsigned NCH      = 2,
  parameter int unsigned DW       = 32,
  parameter int unsigned AW       = 12,
  parameter int unsigned WAKE_DLY = 4
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           tx_sel_i,
  input  logic           tx_write_i,
  input  logic [AW-1:0]  tx_addr_i,
  input  logic [DW-1:0]  tx_wdata_i,
  output logic [DW-1:0]  tx_rdata_o,
  input  logic           rx_sel_i,
  input  logic           rx_write_i,
  input  logic [AW-1:0]  rx_addr_i,
  input  logic [DW-1:0]  rx_wdata_i,
  output logic [DW-1:0]  rx_rdata_o,
  output logic [NCH-1:0] rx_irq_o,
  output logic           rx_awake_o
);
  logic [NCH-1:0]         tx_hit, rx_hit;
  logic [4:0]             tx_off, rx_off;
  logic                   tx_wr, rx_wr, tx_rd, rx_rd, req_wr;
  logic                   wake_req, wake_rdy;
  logic [NCH-1:0][DW-1:0] flags;

  assign tx_wr  = tx_sel_i &  tx_write_i;
  assign tx_rd  = tx_sel_i & ~tx_write_i;
  assign rx_wr  = rx_sel_i &  rx_write_i;
  assign rx_rd  = rx_sel_i & ~rx_write_i;
  assign req_wr = tx_wr & (tx_addr_i == AW'(REQ_ADDR));

  dbell_win_dec #(.NCH(NCH), .AW(AW)) u_tx_dec (
    .addr_i(tx_addr_i), .ch_hit_o(tx_hit), .off_o(tx_off)
  );
  dbell_win_dec #(.NCH(NCH), .AW(AW)) u_rx_dec (
    .addr_i(rx_addr_i), .ch_hit_o(rx_hit), .off_o(rx_off)
  );

  dbell_wake #(.DLY(WAKE_DLY)) u_wake (
    .clk_i, .rst_ni,
    .req_wr_i (req_wr),
    .req_val_i(tx_wdata_i[0]),
    .req_o    (wake_req),
    .rdy_o    (wake_rdy)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic set_en, clr_en;
    assign set_en = tx_wr & wake_rdy & tx_hit[c] & (tx_off == SET_OFS);
    assign clr_en = rx_wr & rx_hit[c] & (rx_off == CLR_OFS);
    dbell_chan #(.DW(DW)) u_chan (
      .clk_i, .rst_ni,
      .set_en_i (set_en),
      .set_val_i(tx_wdata_i),
      .clr_en_i (clr_en),
      .clr_val_i(rx_wdata_i),
      .flag_o   (flags[c]),
      .irq_o    (rx_irq_o[c])
    );
  end

  always_comb begin
    tx_rdata_o = '0;
    if (tx_rd) begin
      if (tx_addr_i == AW'(CAP_ADDR))      tx_rdata_o = DW'(NCH);
      else if (tx_addr_i == AW'(REQ_ADDR)) tx_rdata_o = DW'(wake_req);
      else if (tx_addr_i == AW'(RDY_ADDR)) tx_rdata_o = DW'(wake_rdy);
      else
        for (int c = 0; c < NCH; c++)
          if (tx_hit[c] && tx_off == STAT_OFS) tx_rdata_o = flags[c];
    end
  end

  always_comb begin
    rx_rdata_o = '0;
    if (rx_rd)
      for (int c = 0; c < NCH; c++)
        if (rx_hit[c] && rx_off == STAT_OFS) rx_rdata_o = flags[c];
  end

  assign rx_awake_o = wake_rdy;
endmodule

// File: rtl/dbell_mbox_chk.sv
module dbell_mbox_chk import dbell_pkg::*; #(
  parameter int unsigned NCH = 2,
  parameter int unsigned DW  = 32,
  parameter int unsigned AW  = 12
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   tx_sel_i,
  input logic                   tx_write_i,
  input logic [AW-1:0]          tx_addr_i,
  input logic [DW-1:0]          tx_rdata_o,
  input logic                   rx_sel_i,
  input logic                   rx_write_i,
  input logic [AW-1:0]          rx_addr_i,
  input logic [DW-1:0]          rx_wdata_i,
  input logic [NCH-1:0]         rx_irq_o,
  input logic [NCH-1:0][DW-1:0] flags_i,
  input logic                   req_i,
  input logic                   rdy_i
);
  logic tx_wr, rx_wr, tx_unmapped;
  assign tx_wr = tx_sel_i & tx_write_i;
  assign rx_wr = rx_sel_i & rx_write_i;
  assign tx_unmapped = (tx_addr_i >= AW'(NCH * 32)) && (tx_addr_i < AW'(CAP_ADDR));

  for (genvar c = 0; c < NCH; c++) begin : g_chk
    // R4: new flag bits only after a cycle with ready high
    a_r4_set_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (|(flags_i[c] & ~$past(flags_i[c]))) |-> $past(rdy_i));

    // R5: a full-mask clear with no competing set empties the channel
    a_r5_clear_all: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rx_wr && rx_addr_i == AW'(c * 32 + 8) && rx_wdata_i == '1 &&
       !(tx_wr && tx_addr_i == AW'(c * 32 + 12))) |=> !rx_irq_o[c]);
  end

  a_r8_cap_value: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_sel_i && !tx_write_i && tx_addr_i == AW'(CAP_ADDR)) |-> tx_rdata_o == DW'(NCH));

  a_r9_ready_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rdy_i) |-> (req_i && $past(req_i)));

  a_r10_ready_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> !rdy_i);

  a_r11_unmapped_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_wr && tx_unmapped && !rx_wr) |=> $stable(flags_i));
endmodule

bind dbell_mbox dbell_mbox_chk #(.NCH(NCH), .DW(DW), .AW(AW)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .tx_sel_i  (tx_sel_i),
  .tx_write_i(tx_write_i),
  .tx_addr_i (tx_addr_i),
  .tx_rdata_o(tx_rdata_o),
  .rx_sel_i  (rx_sel_i),
  .rx_write_i(rx_write_i),
  .rx_addr_i (rx_addr_i),
  .rx_wdata_i(rx_wdata_i),
  .rx_irq_o  (rx_irq_o),
  .flags_i   (flags),
  .req_i     (wake_req),
  .rdy_i     (wake_rdy)
);

// File: tb/dbell_mbox_test.sv
`timescale 1ns/1ps
module dbell_mbox_test;
  localparam int unsigned DLY = 4;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        tx_sel_i = 0, tx_write_i = 0, rx_sel_i = 0, rx_write_i = 0;
  logic [11:0] tx_addr_i = '0, rx_addr_i = '0;
  logic [31:0] tx_wdata_i = '0, rx_wdata_i = '0;
  logic [31:0] tx_rdata_o, rx_rdata_o;
  logic [1:0]  rx_irq_o;
  logic        rx_awake_o;

  int n_chk = 0, n_err = 0;
  logic [31:0] mflag [2];
  logic        mrdy;

  always #10 clk_i = ~clk_i;

  dbell_mbox #(.WAKE_DLY(DLY)) uut (.*);

  function automatic logic [31:0] next_flag(logic [31:0] f, logic [31:0] s, logic [31:0] c);
    return (f & ~c) | s;
  endfunction

  task automatic chk(string r, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic rd(bit rx, logic [11:0] a, output logic [31:0] d);
    if (rx) begin rx_sel_i = 1; rx_write_i = 0; rx_addr_i = a; end
    else    begin tx_sel_i = 1; tx_write_i = 0; tx_addr_i = a; end
    #2;
    d = rx ? rx_rdata_o : tx_rdata_o;
    tx_sel_i = 0; rx_sel_i = 0;
  endtask

  // called at a falling edge; one write cycle on either or both frames
  task automatic bus(bit tv, logic [11:0] ta, logic [31:0] td,
                     bit rv, logic [11:0] ra, logic [31:0] rdat);
    tx_sel_i = tv; tx_write_i = tv; tx_addr_i = ta; tx_wdata_i = td;
    rx_sel_i = rv; rx_write_i = rv; rx_addr_i = ra; rx_wdata_i = rdat;
    @(posedge clk_i); @(negedge clk_i);
    tx_sel_i = 0; tx_write_i = 0; rx_sel_i = 0; rx_write_i = 0;
  endtask

  task automatic model(bit tv, logic [11:0] ta, logic [31:0] td,
                       bit rv, logic [11:0] ra, logic [31:0] rdat);
    for (int c = 0; c < 2; c++) begin
      logic [31:0] s, k;
      s = (tv && mrdy && ta == 12'(c * 32 + 12)) ? td : 32'h0;
      k = (rv && ra == 12'(c * 32 + 8)) ? rdat : 32'h0;
      mflag[c] = next_flag(mflag[c], s, k);
    end
  endtask

  task automatic op(bit tv, logic [11:0] ta, logic [31:0] td,
                    bit rv, logic [11:0] ra, logic [31:0] rdat);
    bus(tv, ta, td, rv, ra, rdat);
    model(tv, ta, td, rv, ra, rdat);
  endtask

  task automatic check_all(string r);
    logic [31:0] d;
    for (int c = 0; c < 2; c++) begin
      rd(0, 12'(c * 32), d); chk({r, " R2 tx status"}, d, mflag[c]);
      rd(1, 12'(c * 32), d); chk({r, " R2 rx status"}, d, mflag[c]);
    end
    chk({r, " R7 irq"}, {30'h0, rx_irq_o}, {30'h0, mflag[1] != 0, mflag[0] != 0});
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    n_err++;
    $display("FAIL R1 watchdog actual=hung expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'd2024));
    mflag[0] = 0; mflag[1] = 0; mrdy = 0;
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    // R1 reset state
    chk("R1 irq", {30'h0, rx_irq_o}, 32'h0);
    chk("R1 awake", {31'h0, rx_awake_o}, 32'h0);
    rst_ni = 1;
    @(negedge clk_i);
    rd(0, 12'hF88, d); chk("R1 request", d, 0);
    rd(0, 12'hF8C, d); chk("R1 ready", d, 0);
    check_all("R1");

    // R8 capability
    rd(0, 12'hF80, d); chk("R8 cap", d, 32'd2);

    // R4 set ignored before ready
    op(1, 12'h00C, 32'hFF, 0, 0, 0);
    check_all("R4");

    // R9 wake handshake timing
    bus(1, 12'hF88, 32'h1, 0, 0, 0);
    rd(0, 12'hF88, d); chk("R9 request readback", d, 1);
    rd(0, 12'hF8C, d); chk("R9 ready k=0", d, 0);
    for (int k = 1; k <= int'(DLY); k++) begin
      @(posedge clk_i); @(negedge clk_i);
      rd(0, 12'hF8C, d); chk("R9 ready timing", d, (k >= int'(DLY)) ? 1 : 0);
      chk("R9 awake mirror", {31'h0, rx_awake_o}, (k >= int'(DLY)) ? 1 : 0);
    end
    mrdy = 1;

    // R3 set, R7 per-channel interrupt
    op(1, 12'h00C, 32'h0000_00A5, 0, 0, 0);
    check_all("R3 ch0");
    op(1, 12'h02C, 32'h8000_0001, 0, 0, 0);
    check_all("R3 ch1");
    // R5 clear subset
    op(0, 0, 0, 1, 12'h008, 32'h0000_0005);
    check_all("R5 ch0");
    // R6 set wins on shared bit; disjoint set and clear in same cycle
    op(1, 12'h02C, 32'h1, 1, 12'h028, 32'h1);
    rd(0, 12'h020, d); chk("R6 set wins", d, 32'h8000_0001);
    op(1, 12'h02C, 32'h2, 1, 12'h028, 32'h8000_0000);
    rd(1, 12'h020, d); chk("R6 mixed", d, 32'h0000_0003);
    // R11 unmapped accesses
    op(1, 12'h010, 32'hFFFF_FFFF, 1, 12'h00C, 32'hFFFF_FFFF);
    op(1, 12'h040, 32'hFFFF_FFFF, 1, 12'h048, 32'hFFFF_FFFF);
    check_all("R11 writes");
    rd(0, 12'h00C, d); chk("R11 set reads zero", d, 0);
    rd(1, 12'h008, d); chk("R11 clr reads zero", d, 0);
    rd(1, 12'hF8C, d); chk("R11 rx ready absent", d, 0);
    rd(1, 12'hF80, d); chk("R11 rx cap absent", d, 0);
    rd(0, 12'h100, d); chk("R11 tx unmapped", d, 0);
    // R5 clear everything
    op(0, 0, 0, 1, 12'h008, 32'hFFFF_FFFF);
    op(0, 0, 0, 1, 12'h028, 32'hFFFF_FFFF);
    check_all("R5 clear all");

    // random traffic
    for (int i = 0; i < 400; i++) begin
      int unsigned kind;
      logic [11:0] ta, ra;
      logic [31:0] td, rdat;
      kind = $urandom % 4;
      ta = 12'(($urandom % 2) * 32 + 12);
      ra = 12'(($urandom % 2) * 32 + 8);
      td = $urandom & $urandom;
      rdat = $urandom | $urandom;
      case (kind)
        0: op(1, ta, td, 0, 0, 0);
        1: op(0, 0, 0, 1, ra, rdat);
        2: op(1, ta, td, 1, ra, rdat);
        default: op(1, 12'(12'h040 + ($urandom % 64) * 4), td, 1, 12'h004, rdat);
      endcase
      check_all("R3 R5 R6 random");
    end

    // R10 ready falls after request dropped, R4 sets ignored again
    bus(1, 12'hF88, 32'h0, 0, 0, 0);
    rd(0, 12'hF88, d); chk("R10 request cleared", d, 0);
    rd(0, 12'hF8C, d); chk("R10 ready before fall", d, 1);
    @(posedge clk_i); @(negedge clk_i);
    mrdy = 0;
    rd(0, 12'hF8C, d); chk("R10 ready fallen", d, 0);
    chk("R10 awake fallen", {31'h0, rx_awake_o}, 0);
    op(1, 12'h00C, 32'h0F0F_0000, 0, 0, 0);
    op(1, 12'h02C, 32'h0000_F0F0, 0, 0, 0);
    check_all("R4 after drop");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end
endmodule